// File: doc/BRIEF.md
# Host status and interrupt controller

This block keeps the event status of a memory-card host controller and turns it into one interrupt request. The command, data, buffer, SDIO and card-detect logic send single-cycle event pulses. The block latches each pulse into a sticky bit of a 32-bit status word. Software clears a sticky bit by writing a one to it. Other fields of the same word show live conditions: the buffer fill flags, the two buffer-ready flags and the write CRC status code. These fields follow their inputs and ignore writes.

A separate enable register selects which latched events, ready levels and the DAT0 level may raise `irq_o`. Three more enable bits, held apart from the interrupt enables, select which card and SDIO events raise the wakeup output. The block also drives an error summary over the fixed error group. A further output flags a write CRC error whose status code reports that the card sent no CRC response. Software reaches both registers through a simple read/write port. Reads are combinational on the address.

Top module: `stint_ctrl`

## Requirements
- R1: After reset the sticky status bits and the enable register read 0, and `irq_o`, `wake_o`, `err_o` and `crc_nores_o` are 0.
- R2: A pulse on `evt_i` at a sticky position sets that status bit one clock later, and the bit stays set while it is not cleared. The sticky positions are 31 (card inserted), 30 (card removed), 25 (underrun), 24 (overflow), 14 (SDIO interrupt), 13 (command response end), 12 (write done), 11 (read/transfer done), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) and 0 (read timeout). Together they form the mask 0xC300782F.
- R3: A write to the status address (address 0) clears every sticky bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If a clear and an event pulse hit the same sticky bit in the same cycle, the bit ends up set.
- R5: The live fields show their inputs directly: `bufstat_i[3:0]` at bits 29:26 (Y empty, X empty, Y full, X full), `rd_rdy_i` at bit 7, `wr_rdy_i` at bit 6 and `wcrc_code_i` at bits 10:9. Writes to the status address do not change them.
- R6: Event pulses at non-sticky positions are ignored. With the live inputs at 0, the status word then reads 0.
- R7: The enable register sits at address 1. It holds only the bits of mask 0x0007F01F, and every other bit reads 0. It changes only on a write to address 1.
- R8: `irq_o` is high exactly when at least one of these pairs is active: enable bit 0 with status 11, enable bit 1 with status 12, enable bit 2 with status 13, enable bit 3 with `wr_rdy_i`, enable bit 4 with `rd_rdy_i`, enable bit 12 with `dat0_i`, enable bit 13 with status 14, enable bit 14 with status 30, or enable bit 15 with status 31. Error bits and buffer faults never raise it.
- R9: `wake_o` is high exactly when enable bit 16 meets status 30, enable bit 17 meets status 31, or enable bit 18 meets status 14. The wake enables never raise `irq_o`.
- R10: `err_o` is high while any status bit of the error mask 0x2F is set.
- R11: `crc_nores_o` is high while status bit 2 is set and `wcrc_code_i` equals 2. For any other code it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 status, 1 enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_i | input | 32 | Event pulses, one bit per status position |
| bufstat_i | input | 4 | Live buffer flags {Y empty, X empty, Y full, X full} |
| rd_rdy_i | input | 1 | Live buffer read-ready level |
| wr_rdy_i | input | 1 | Live buffer write-ready level |
| wcrc_code_i | input | 2 | Live write CRC status code |
| dat0_i | input | 1 | DAT0 level interrupt source |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |
| err_o | output | 1 | Any error-group bit latched |
| crc_nores_o | output | 1 | Write CRC error with no CRC response |

## Verification
The two functions that can meet in one cycle are the software clear and a new event on the same sticky bit. The bench raises the event pulse and the clear write at the same falling edge, so both reach the register at the same rising edge. Afterwards it reads the status word and expects the bit to be set. A second clear that arrives alone must then bring the bit back to 0, which shows the earlier clear was not simply dropped.

// File: rtl/stint_pkg.sv
package stint_pkg;
  localparam int DATA_W = 32;
  localparam int BUF_W  = 4;

  // Status positions (decoded by software, so kept fixed)
  localparam int S_CARD_IN  = 31;
  localparam int S_CARD_OUT = 30;
  localparam int S_BUF_LO   = 26;
  localparam int S_RD_DONE  = 11;
  localparam int S_WR_DONE  = 12;
  localparam int S_CMD_END  = 13;
  localparam int S_SDIO     = 14;
  localparam int S_CODE_LO  = 9;
  localparam int S_RD_RDY   = 7;
  localparam int S_WR_RDY   = 6;
  localparam int S_WCRC     = 2;

  // Enable positions
  localparam int E_RD_DONE  = 0;
  localparam int E_WR_DONE  = 1;
  localparam int E_CMD_END  = 2;
  localparam int E_WR_RDY   = 3;
  localparam int E_RD_RDY   = 4;
  localparam int E_DAT0     = 12;
  localparam int E_SDIO     = 13;
  localparam int E_CARD_OUT = 14;
  localparam int E_CARD_IN  = 15;
  localparam int W_CARD_OUT = 16;
  localparam int W_CARD_IN  = 17;
  localparam int W_SDIO     = 18;

  localparam logic [DATA_W-1:0] STICKY_MASK = 32'hC300_782F;
  localparam logic [DATA_W-1:0] LIVE_MASK   = 32'h3C00_06C0;
  localparam logic [DATA_W-1:0] EN_MASK     = 32'h0007_F01F;
  localparam logic [DATA_W-1:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [1:0]        CODE_NORESP = 2'd2;

  function automatic logic [DATA_W-1:0] f_live(input logic [BUF_W-1:0] bufs,
                                                input logic rd_rdy,
                                                input logic wr_rdy,
                                                input logic [1:0] code);
    logic [DATA_W-1:0] v;
    v = '0;
    v[S_BUF_LO +: BUF_W] = bufs;
    v[S_CODE_LO +: 2]    = code;
    v[S_RD_RDY]          = rd_rdy;
    v[S_WR_RDY]          = wr_rdy;
    return v;
  endfunction

  function automatic logic f_irq(input logic [DATA_W-1:0] st,
                                 input logic [DATA_W-1:0] en,
                                 input logic dat0);
    return (en[E_RD_DONE]  & st[S_RD_DONE])  |
           (en[E_WR_DONE]  & st[S_WR_DONE])  |
           (en[E_CMD_END]  & st[S_CMD_END])  |
           (en[E_WR_RDY]   & st[S_WR_RDY])   |
           (en[E_RD_RDY]   & st[S_RD_RDY])   |
           (en[E_DAT0]     & dat0)           |
           (en[E_SDIO]     & st[S_SDIO])     |
           (en[E_CARD_OUT] & st[S_CARD_OUT]) |
           (en[E_CARD_IN]  & st[S_CARD_IN]);
  endfunction

  function automatic logic f_wake(input logic [DATA_W-1:0] st,
                                  input logic [DATA_W-1:0] en);
    return (en[W_CARD_OUT] & st[S_CARD_OUT]) |
           (en[W_CARD_IN]  & st[S_CARD_IN])  |
           (en[W_SDIO]     & st[S_SDIO]);
  endfunction

  function automatic logic f_err(input logic [DATA_W-1:0] st);
    return |(st & ERR_MASK);
  endfunction

  function automatic logic f_nores(input logic [DATA_W-1:0] st);
    return st[S_WCRC] && (st[S_CODE_LO +: 2] == CODE_NORESP);
  endfunction
endpackage

// File: rtl/stint_sticky.sv
module stint_sticky
  import stint_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = STICKY_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] st_o
);
  logic [DATA_W-1:0] st_q;
  logic [DATA_W-1:0] st_d;

  // A new event has priority over a same-cycle clear
  always_comb st_d = ((st_q & ~clr_i) | set_i) & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_chk
    if (MASK[i]) begin : g_live_bit
      assert_event_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> st_q[i]);
      assert_bit_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[i] && !clr_i[i]) |=> st_q[i]);
      assert_bit_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !st_q[i]);
    end else begin : g_dead_bit
      assert_inert_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> !st_q[i]);
    end
  end
endmodule

// File: rtl/stint_enable.sv
module stint_enable
  import stint_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = EN_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);
  logic [DATA_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (we_i) en_q <= wdata_i & MASK;
  end

  assign en_o = en_q;

  assert_en_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_q));
  assert_en_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((en_q & ~MASK) == '0));
endmodule

// File: rtl/stint_merge.sv
module stint_merge
  import stint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic              dat0_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              err_o,
  output logic              nores_o
);
  always_comb begin
    irq_o   = f_irq(status_i, en_i, dat0_i);
    wake_o  = f_wake(status_i, en_i);
    err_o   = f_err(status_i);
    nores_o = f_nores(status_i);
  end

  assert_no_irq_unenabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i[15:0] == '0) |-> !irq_o);
  assert_no_wake_unenabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i[18:16] == '0) |-> !wake_o);
  assert_nores_needs_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nores_o |-> err_o);
endmodule

// File: rtl/stint_ctrl.sv
module stint_ctrl
  import stint_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int ST_ADDR = 0,
  parameter int EN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       evt_i,
  input  logic [3:0]        bufstat_i,
  input  logic              rd_rdy_i,
  input  logic              wr_rdy_i,
  input  logic [1:0]        wcrc_code_i,
  input  logic              dat0_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              err_o,
  output logic              crc_nores_o
);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ST_ADDR);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_ADDR);

  // Named internal events
  logic              wr_status;
  logic              wr_enable;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] sticky_q;
  logic [DATA_W-1:0] live_vec;
  logic [DATA_W-1:0] status_vec;
  logic [DATA_W-1:0] enable_q;

  assign wr_status = reg_wr && (reg_addr == A_ST);
  assign wr_enable = reg_wr && (reg_addr == A_EN);
  assign clr_vec   = wr_status ? reg_wdata : '0;

  stint_sticky #(.MASK(STICKY_MASK)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i),
    .clr_i (clr_vec),
    .st_o  (sticky_q)
  );

  stint_enable #(.MASK(EN_MASK)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_enable),
    .wdata_i (reg_wdata),
    .en_o    (enable_q)
  );

  always_comb begin
    live_vec   = f_live(bufstat_i, rd_rdy_i, wr_rdy_i, wcrc_code_i);
    status_vec = (sticky_q & STICKY_MASK) | (live_vec & LIVE_MASK);
  end

  always_comb begin
    if (reg_addr == A_ST)      reg_rdata = status_vec;
    else if (reg_addr == A_EN) reg_rdata = enable_q;
    else                       reg_rdata = '0;
  end

  stint_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_vec),
    .en_i     (enable_q),
    .dat0_i   (dat0_i),
    .irq_o    (irq_o),
    .wake_o   (wake_o),
    .err_o    (err_o),
    .nores_o  (crc_nores_o)
  );

  assert_sticky_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sticky_q == '0));
  assert_live_ignores_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && $stable(live_vec)) |=> ((status_vec & LIVE_MASK) == $past(live_vec)));
endmodule

// File: tb/tb_stint_ctrl.sv
module tb_stint_ctrl;
  localparam int CLK_P = 10;
  localparam logic [31:0] STICKY = 32'hC300_782F;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_i = 0;
  logic [3:0]  bufstat_i = 0;
  logic        rd_rdy_i = 0, wr_rdy_i = 0, dat0_i = 0;
  logic [1:0]  wcrc_code_i = 0;
  logic        irq_o, wake_o, err_o, crc_nores_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  stint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .bufstat_i(bufstat_i), .rd_rdy_i(rd_rdy_i), .wr_rdy_i(wr_rdy_i),
    .wcrc_code_i(wcrc_code_i), .dat0_i(dat0_i), .irq_o(irq_o),
    .wake_o(wake_o), .err_o(err_o), .crc_nores_o(crc_nores_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); evt_i = m;
    @(negedge clk); evt_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    chk("R1 outputs", {28'd0, irq_o, wake_o, err_o, crc_nores_o}, 0);
  endtask

  task automatic t_set_hold();
    logic [31:0] v;
    pulse(32'h8000_2000);
    rd(0, v); chk("R2 set", v, 32'h8000_2000);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R2 hold", v, 32'h8000_2000);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(0, 32'h0000_2000);
    rd(0, v); chk("R3 partial clear", v, 32'h8000_0000);
    wr(0, 32'h0);
    rd(0, v); chk("R3 zero write keeps", v, 32'h8000_0000);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R3 full clear", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    evt_i = 32'h0000_1000; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0000_1000;
    @(negedge clk);
    evt_i = 0; reg_wr = 0; reg_wdata = 0;
    rd(0, v); chk("R4 event beats clear", v, 32'h0000_1000);
    wr(0, 32'h0000_1000);
    rd(0, v); chk("R4 later clear", v, 0);
  endtask

  task automatic t_live();
    logic [31:0] v;
    @(negedge clk); bufstat_i = 4'b1010; rd_rdy_i = 1; wcrc_code_i = 2'b10;
    rd(0, v); chk("R5 live fields", v, 32'h2800_0480);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R5 live ignores write", v, 32'h2800_0480);
    @(negedge clk); bufstat_i = 4'b0101; rd_rdy_i = 0; wr_rdy_i = 1; wcrc_code_i = 2'b01;
    rd(0, v); chk("R5 live follows", v, 32'h1400_0240);
    @(negedge clk); bufstat_i = 0; wr_rdy_i = 0; wcrc_code_i = 0;
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    pulse(~STICKY);
    rd(0, v); chk("R6 non-sticky pulses ignored", v, 0);
  endtask

  task automatic t_enable_reg();
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R7 enable mask", v, 32'h0007_F01F);
    wr(0, 32'hFFFF_FFFF);
    rd(1, v); chk("R7 status write leaves enable", v, 32'h0007_F01F);
    wr(2, 32'h0);
    rd(1, v); chk("R7 other address leaves enable", v, 32'h0007_F01F);
    rd(2, v); chk("R7 unmapped reads 0", v, 0);
    wr(1, 32'h0);
  endtask

  task automatic t_irq_map();
    int en_b[6] = '{0, 1, 2, 13, 14, 15};
    int st_b[6] = '{11, 12, 13, 14, 30, 31};
    for (int k = 0; k < 6; k++) begin
      wr(1, 32'h1 << en_b[k]);
      chk($sformatf("R8 idle en%0d", en_b[k]), {31'd0, irq_o}, 0);
      pulse(32'h1 << st_b[k]);
      chk($sformatf("R8 en%0d/st%0d", en_b[k], st_b[k]), {31'd0, irq_o}, 1);
      wr(1, ~(32'h1 << en_b[k]) & 32'h0000_F01F);
      chk($sformatf("R8 other enables en%0d", en_b[k]), {31'd0, irq_o}, 0);
      wr(0, 32'h1 << st_b[k]);
    end
    wr(1, 32'h0000_1018);
    @(negedge clk); wr_rdy_i = 1; #1;
    chk("R8 write ready level", {31'd0, irq_o}, 1);
    @(negedge clk); wr_rdy_i = 0; rd_rdy_i = 1; #1;
    chk("R8 read ready level", {31'd0, irq_o}, 1);
    @(negedge clk); rd_rdy_i = 0; dat0_i = 1; #1;
    chk("R8 dat0 level", {31'd0, irq_o}, 1);
    @(negedge clk); dat0_i = 0; #1;
    chk("R8 levels gone", {31'd0, irq_o}, 0);
    wr(1, 32'h0000_F01F);
    pulse(32'h0300_002F);
    chk("R8 errors and faults do not interrupt", {31'd0, irq_o}, 0);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 0);
  endtask

  task automatic t_wake();
    int w_b[3] = '{16, 17, 18};
    int s_b[3] = '{30, 31, 14};
    for (int k = 0; k < 3; k++) begin
      wr(1, 32'h1 << w_b[k]);
      pulse(32'h1 << s_b[k]);
      chk($sformatf("R9 wake en%0d", w_b[k]), {30'd0, wake_o, irq_o}, 2'b10);
      wr(1, 0);
      chk($sformatf("R9 wake off en%0d", w_b[k]), {31'd0, wake_o}, 0);
      wr(0, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_err();
    pulse(32'h0000_0010);
    chk("R10 bit4 not error", {31'd0, err_o}, 0);
    pulse(32'h0000_0020);
    chk("R10 response CRC error", {31'd0, err_o}, 1);
    wr(0, 32'h20);
    chk("R10 cleared", {31'd0, err_o}, 0);
    pulse(32'h0000_0001);
    chk("R10 read timeout", {31'd0, err_o}, 1);
    wr(0, 32'h1);
  endtask

  task automatic t_crc();
    @(negedge clk); wcrc_code_i = 2'd2;
    #1 chk("R11 code alone", {31'd0, crc_nores_o}, 0);
    pulse(32'h0000_0004);
    chk("R11 no response", {31'd0, crc_nores_o}, 1);
    @(negedge clk); wcrc_code_i = 2'd1;
    #1 chk("R11 other code", {31'd0, crc_nores_o}, 0);
    wr(0, 32'h4);
    @(negedge clk); wcrc_code_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_hold();
    t_clear();
    t_collide();
    t_live();
    t_ignored();
    t_enable_reg();
    t_irq_map();
    t_wake();
    t_err();
    t_crc();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule